// File: doc/BRIEF.md
# Serial Command Front End for a Two-Channel Converter

This block is the serial slave that sits between an external host and a converter sequencer. The host opens a transaction by pulling the select line low. It then clocks in one 8-bit instruction and clocks out a 16-bit answer. The serial clock idles high. The slave samples input bits on rising clock edges and changes its output bit after falling edges. Both words travel most significant bit first. The block recognises three instructions: a status query, a control word, and a result fetch. The control word carries an enable bit and a channel bit, and it starts a conversion.

The block keeps the enable and channel bits itself. It reads the end-of-conversion flag, the 11-bit result and an initialisation busy flag from the neighbouring logic. It gives the converter a one-cycle start pulse and the selected channel. A command that cannot be accepted gets a refusal word instead of the normal answer. The serial lines are oversampled by the system clock, so the serial clock must stay below roughly one eighth of the system clock rate.

Top module: `spi_adc_cmd_if`

## Requirements
- R1: Instruction bits are taken on rising serial clock edges, MSB first. Answer bit 15 appears on the data output after the first falling edge that follows the 8th rising edge. Each later falling edge presents the next lower bit.
- R2: Instruction 0x88 (status) answers with bit 13 = end-of-conversion flag, bit 3 = channel, bit 2 = enable, and every other bit 0.
- R3: An instruction matching 1001_CE00 (C at bit 3 = channel, E at bit 2 = enable) is accepted when the end-of-conversion flag is 1 and busy is 0. It loads channel and enable, and it answers in the status layout using the new values and the flag as sampled at decode.
- R4: An accepted control instruction with E = 1 produces exactly one single-cycle start pulse. With E = 0 it produces none.
- R5: Instruction 0x80 (fetch) answers with bit 13 = end-of-conversion flag, bits 11..1 = result, and bits 15, 14, 12 and 0 = 0. The result field reads 0 while the flag is 0.
- R6: Any instruction outside the three codes is refused. The answer has bit 15 = 1, bit 14 = 1, bit 13 = end-of-conversion flag, bit 10 = busy, and other bits 0. Channel and enable are unchanged and no start pulse is given.
- R7: A control instruction that arrives while the end-of-conversion flag is 0 is refused with bit 15 = 1 and bit 14 = 0. Channel and enable are unchanged and no start pulse is given.
- R8: While busy is 1, every instruction is refused with bit 10 = 1. Bit 14 is 1 only for an unknown code.
- R9: The data output is 0 while select is high and during the eight instruction bits.
- R10: If select rises before the 8th rising edge, the instruction is discarded with no change to channel or enable and no start pulse.
- R11: If select rises after the 8th rising edge, only the answer is cut short. The command still takes effect and the conversion it started still completes.
- R12: After reset, enable = 0, channel = 0, start = 0 and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Slave select, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | input | 1 | Initialisation in progress; every command is refused |
| conv_eoc | input | 1 | End-of-conversion flag from the converter |
| conv_data | input | 11 | Last conversion result |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| conv_chan | output | 1 | Selected channel held by the block |
| conv_enable | output | 1 | Converter enable held by the block |

## Verification
The conflict that matters is a conversion finishing on the same system clock in which a control instruction is decoded. The flag sampled in that cycle alone decides whether the command is accepted or refused. The bench starts a conversion and then sends a second control word. It sweeps the conversion length one cycle at a time so that the flag rises before, on, and after the decode cycle. Each outcome is judged for consistency: an accepted answer must show the flag set and must come with a start pulse, while a refusal must show the flag clear, bit 14 clear and no pulse. Both outcomes must occur somewhere in the sweep.

// File: rtl/spi_adc_pkg.sv
// Package: shared constants, command type and answer-word builders for the
// serial converter command front end. Assumes fixed 8-bit instructions and
// 16-bit answers; field positions here are decoded by the host.
package spi_adc_pkg;

    localparam int INSTR_BITS  = 8;
    localparam int ANSWER_BITS = 16;
    localparam int RESULT_BITS = 11;

    localparam logic [INSTR_BITS-1:0] OP_STATUS    = 8'h88;
    localparam logic [INSTR_BITS-1:0] OP_FETCH     = 8'h80;
    localparam logic [INSTR_BITS-1:0] OP_CTRL_MASK = 8'hF3;
    localparam logic [INSTR_BITS-1:0] OP_CTRL_CODE = 8'h90;

    localparam int CTRL_CHAN_POS = 3;
    localparam int CTRL_EN_POS   = 2;

    typedef enum logic [1:0] {
        CMD_STATUS,
        CMD_CTRL,
        CMD_FETCH,
        CMD_UNKNOWN
    } cmd_kind_e;

    // Sort an instruction byte into one of the command kinds.
    function automatic cmd_kind_e classify_op(input logic [INSTR_BITS-1:0] op);
        if (op == OP_STATUS) return CMD_STATUS;
        if (op == OP_FETCH) return CMD_FETCH;
        if ((op & OP_CTRL_MASK) == OP_CTRL_CODE) return CMD_CTRL;
        return CMD_UNKNOWN;
    endfunction

    // Status / control answer: flag at 13, channel at 3, enable at 2.
    function automatic logic [ANSWER_BITS-1:0] pack_status(input logic eoc,
                                                           input logic chan,
                                                           input logic en);
        return {2'b00, eoc, 9'd0, chan, en, 2'b00};
    endfunction

    // Fetch answer: flag at 13, result at 11..1, result masked while flag low.
    function automatic logic [ANSWER_BITS-1:0] pack_fetch(input logic eoc,
                                                          input logic [RESULT_BITS-1:0] res);
        return {2'b00, eoc, 1'b0, (eoc ? res : {RESULT_BITS{1'b0}}), 1'b0};
    endfunction

    // Refusal answer: top bit set, unknown-code at 14, flag at 13, busy at 10.
    function automatic logic [ANSWER_BITS-1:0] pack_refusal(input logic unknown,
                                                            input logic eoc,
                                                            input logic bsy);
        return {1'b1, unknown, eoc, 2'b00, bsy, 10'd0};
    endfunction

endpackage

// File: rtl/spi_adc_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed) and that the
// reset value matches the idle level of each line.
module spi_adc_sync #(
    parameter int                WIDTH     = 3,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RESET_VAL;
        end else begin
            pipe[0] <= async_in;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/spi_adc_frame.sv
// Module: serial framing for clock-idle-high, sample-on-rise transfers.
// Collects the instruction on rising edges, flags it after the last
// instruction bit, loads the answer word one cycle later and shifts it out
// on falling edges. Assumes synchronised inputs and a serial clock slow
// enough that each level lasts several system clocks.
module spi_adc_frame
    import spi_adc_pkg::*;
#(
    parameter int INSTR_W = INSTR_BITS,
    parameter int ANS_W   = ANSWER_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               ss_n_s,
    input  logic               mosi_s,
    input  logic [ANS_W-1:0]   answer,
    output logic               instr_valid,
    output logic [INSTR_W-1:0] instr,
    output logic               miso_q
);

    localparam int             FRAME_W    = INSTR_W + ANS_W;
    localparam int             CNT_W      = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] FIRST_ANS  = CNT_W'(INSTR_W);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(FRAME_W);

    logic             sclk_q;
    logic [CNT_W-1:0] edge_cnt;
    logic [ANS_W-1:0] ans_sr;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             in_answer;

    assign sclk_rise = sclk_s & ~sclk_q & ~ss_n_s;
    assign sclk_fall = ~sclk_s & sclk_q & ~ss_n_s;
    assign in_answer = (edge_cnt >= FIRST_ANS);

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_s;
    end

    // Count rising edges within one select-low window, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                            edge_cnt <= '0;
        else if (ss_n_s)                       edge_cnt <= '0;
        else if (sclk_rise && edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
    end

    // Shift instruction bits in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        instr <= '0;
        else if (ss_n_s)   instr <= '0;
        else if (sclk_rise && edge_cnt <= LAST_INSTR)
            instr <= {instr[INSTR_W-2:0], mosi_s};
    end

    // Flag the instruction once its last bit has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) instr_valid <= 1'b0;
        else        instr_valid <= sclk_rise && (edge_cnt == LAST_INSTR);
    end

    // Load the answer after decode and shift it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ans_sr <= '0;
        else if (ss_n_s)                   ans_sr <= '0;
        else if (instr_valid)              ans_sr <= answer;
        else if (sclk_fall && in_answer)   ans_sr <= {ans_sr[ANS_W-2:0], 1'b0};
    end

    // Present the current answer bit after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                        miso_q <= 1'b0;
        else if (ss_n_s)                   miso_q <= 1'b0;
        else if (sclk_fall && in_answer)   miso_q <= ans_sr[ANS_W-1];
        else if (sclk_fall)                miso_q <= 1'b0;
    end

endmodule

// File: rtl/spi_adc_decode.sv
// Module: command decode and control state. Classifies the instruction,
// decides acceptance from busy and the end-of-conversion flag sampled in
// the decode cycle, builds the answer word and updates channel/enable.
// Assumes instr_valid is a one-cycle pulse with instr stable.
module spi_adc_decode
    import spi_adc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   instr_valid,
    input  logic [INSTR_BITS-1:0]  instr,
    input  logic                   busy,
    input  logic                   conv_eoc,
    input  logic [RESULT_BITS-1:0] conv_data,
    output logic [ANSWER_BITS-1:0] answer,
    output logic                   conv_start,
    output logic                   conv_chan,
    output logic                   conv_enable
);

    cmd_kind_e kind;
    logic      refuse;
    logic      ctrl_ok;
    logic      op_chan;
    logic      op_en;

    assign kind    = classify_op(instr);
    assign op_chan = instr[CTRL_CHAN_POS];
    assign op_en   = instr[CTRL_EN_POS];
    assign refuse  = busy || (kind == CMD_UNKNOWN) || (kind == CMD_CTRL && !conv_eoc);
    assign ctrl_ok = instr_valid && !refuse && (kind == CMD_CTRL);

    // Choose the answer word for the decoded instruction.
    always_comb begin
        if (refuse) begin
            answer = pack_refusal(kind == CMD_UNKNOWN, conv_eoc, busy);
        end else begin
            unique case (kind)
                CMD_STATUS: answer = pack_status(conv_eoc, conv_chan, conv_enable);
                CMD_CTRL:   answer = pack_status(conv_eoc, op_chan, op_en);
                CMD_FETCH:  answer = pack_fetch(conv_eoc, conv_data);
                default:    answer = '0;
            endcase
        end
    end

    // Hold channel and enable; load them on an accepted control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_chan   <= 1'b0;
            conv_enable <= 1'b0;
        end else if (ctrl_ok) begin
            conv_chan   <= op_chan;
            conv_enable <= op_en;
        end
    end

    // Pulse start for an accepted control word that enables the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_start <= 1'b0;
        else        conv_start <= ctrl_ok && op_en;
    end

endmodule

// File: rtl/spi_adc_cmd_if.sv
// Module: top of the serial converter command front end. Synchronises the
// serial lines into the system clock, frames transfers, decodes commands
// and forces the data output low whenever select is high.
// Assumes the serial clock is at most about one eighth of clk.
module spi_adc_cmd_if
    import spi_adc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ss_n,
    input  logic                   sclk,
    input  logic                   mosi,
    output logic                   miso,
    input  logic                   busy,
    input  logic                   conv_eoc,
    input  logic [RESULT_BITS-1:0] conv_data,
    output logic                   conv_start,
    output logic                   conv_chan,
    output logic                   conv_enable
);

    localparam int LINES = 3;

    logic [LINES-1:0]       lines_s;
    logic                   instr_valid;
    logic [INSTR_BITS-1:0]  instr;
    logic [ANSWER_BITS-1:0] answer;
    logic                   miso_q;

    spi_adc_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b110)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sclk, ss_n, mosi}),
        .sync_out (lines_s)
    );

    spi_adc_frame #(
        .INSTR_W (INSTR_BITS),
        .ANS_W   (ANSWER_BITS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (lines_s[2]),
        .ss_n_s      (lines_s[1]),
        .mosi_s      (lines_s[0]),
        .answer      (answer),
        .instr_valid (instr_valid),
        .instr       (instr),
        .miso_q      (miso_q)
    );

    spi_adc_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .busy        (busy),
        .conv_eoc    (conv_eoc),
        .conv_data   (conv_data),
        .answer      (answer),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_enable (conv_enable)
    );

    // Output is quiet as soon as select goes high, without synchroniser delay.
    assign miso = miso_q & ~ss_n;

endmodule

// File: rtl/spi_adc_cmd_if_chk.sv
// Module: property checker for the command front end, bound to the top.
// Assumes it sees the top-level ports only.
module spi_adc_cmd_if_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_n,
    input logic miso,
    input logic busy,
    input logic conv_eoc,
    input logic conv_start,
    input logic conv_chan,
    input logic conv_enable
);

    assert_quiet_when_deselected_R9: assert property (
        @(posedge clk) disable iff (!rst_n) ss_n |-> !miso);

    assert_start_single_cycle_R4: assert property (
        @(posedge clk) disable iff (!rst_n) conv_start |=> !conv_start);

    assert_start_only_enabled_R4: assert property (
        @(posedge clk) disable iff (!rst_n) conv_start |-> conv_enable);

    assert_start_needs_idle_converter_R7: assert property (
        @(posedge clk) disable iff (!rst_n) conv_start |-> $past(conv_eoc));

    assert_start_blocked_by_busy_R8: assert property (
        @(posedge clk) disable iff (!rst_n) conv_start |-> !$past(busy));

    assert_chan_change_accepted_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(conv_chan) |-> ($past(conv_eoc) && !$past(busy)));

    assert_enable_change_accepted_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(conv_enable) |-> ($past(conv_eoc) && !$past(busy)));

endmodule

bind spi_adc_cmd_if spi_adc_cmd_if_chk u_chk (.*);

// File: tb/spi_adc_cmd_if_tb.sv
// Bench: drives a serial host and a converter model, sweeps every opcode
// and the end-of-conversion race window, computes answers arithmetically.
module spi_adc_cmd_if_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int HALF        = 4;
    localparam int BUSY_CYCLES = 1200;
    localparam int WATCHDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_n = 1'b1;
    logic        sclk = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        busy = 1'b1;
    logic        conv_eoc;
    logic [10:0] conv_data;
    logic        conv_start;
    logic        conv_chan;
    logic        conv_enable;

    int n_checks = 0;
    int n_errs   = 0;
    int conv_len = 20;
    int conv_left;
    int conv_count;
    int start_cnt;
    bit quiet_bad = 1'b0;
    logic [15:0] ans;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_adc_cmd_if u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ss_n        (ss_n),
        .sclk        (sclk),
        .mosi        (mosi),
        .miso        (miso),
        .busy        (busy),
        .conv_eoc    (conv_eoc),
        .conv_data   (conv_data),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_enable (conv_enable)
    );

    // Converter model: flag low for conv_len cycles after a start pulse.
    always @(posedge clk) begin
        if (!rst_n) begin
            conv_eoc   <= 1'b1;
            conv_data  <= 11'd0;
            conv_left  <= 0;
            conv_count <= 0;
        end else if (conv_start) begin
            conv_eoc  <= 1'b0;
            conv_left <= conv_len;
        end else if (!conv_eoc) begin
            if (conv_left <= 1) begin
                conv_eoc   <= 1'b1;
                conv_count <= conv_count + 1;
                conv_data  <= 11'((conv_count * 163 + (conv_chan ? 1024 : 0) + 5) % 2048);
            end else begin
                conv_left <= conv_left - 1;
            end
        end
    end

    // Count start pulses seen at the port.
    always @(posedge clk) begin
        if (!rst_n)          start_cnt <= 0;
        else if (conv_start) start_cnt <= start_cnt + 1;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One host transfer with `edges` rising edges; answer bits land in ans.
    task automatic xfer(input logic [7:0] op, input int edges);
        ans  = 16'h0;
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < edges; i++) begin
            sclk = 1'b0;
            mosi = (i < 8) ? op[7-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 8) begin
                if (miso !== 1'b0) quiet_bad = 1'b1;
            end else if (i < 24) begin
                ans[23-i] = miso;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        ss_n = 1'b1;
        mosi = 1'b0;
        @(negedge clk);
        if (miso !== 1'b0) quiet_bad = 1'b1;
        repeat (4*HALF - 1) @(negedge clk);
    endtask

    task automatic wait_eoc();
        while (conv_eoc !== 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R1: watchdog expired, actual running expected done");
        finish_run();
    end

    initial begin
        repeat (BUSY_CYCLES) @(posedge clk);
        busy = 1'b0;
    end

    initial begin
        bit en_m, ch_m;
        int s0, exp, acc_seen, ref_seen;
        en_m = 1'b0; ch_m = 1'b0; acc_seen = 0; ref_seen = 0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(conv_enable === 1'b0 && conv_chan === 1'b0, "R12 enable/channel", {conv_enable, conv_chan}, 0);
        check(conv_start === 1'b0 && miso === 1'b0, "R12 start/miso", {conv_start, miso}, 0);

        // R8: every command refused while busy
        xfer(8'h88, 24);
        check(ans == 16'hA400, "R8 status while busy", ans, 16'hA400);
        xfer(8'h00, 24);
        check(ans == 16'hE400, "R8 unknown while busy", ans, 16'hE400);
        s0 = start_cnt;
        xfer(8'h9C, 24);
        check(ans == 16'hA400 && start_cnt == s0 && conv_enable == 1'b0,
              "R8 control while busy", ans, 16'hA400);
        xfer(8'h80, 24);
        check(ans == 16'hA400, "R8 fetch while busy", ans, 16'hA400);

        while (busy) @(negedge clk);

        // R1 R2 R3 R4 R5 R6: sweep of every instruction byte
        for (int op = 0; op < 256; op++) begin
            wait_eoc();
            s0 = start_cnt;
            xfer(8'(op), 24);
            if (op == 8'h88) begin
                exp = 32'h2000 + (ch_m ? 8 : 0) + (en_m ? 4 : 0);
                check(ans == 16'(exp), "R2 status answer", ans, exp);
            end else if (op == 8'h80) begin
                exp = 32'h2000 + 2 * int'(conv_data);
                check(ans == 16'(exp), "R5 fetch answer", ans, exp);
            end else if ((op & 8'hF3) == 8'h90) begin
                ch_m = op[3];
                en_m = op[2];
                exp  = 32'h2000 + (ch_m ? 8 : 0) + (en_m ? 4 : 0);
                check(ans == 16'(exp), "R3 control answer", ans, exp);
                check(conv_chan == ch_m && conv_enable == en_m, "R3 control state",
                      {conv_chan, conv_enable}, {ch_m, en_m});
                check(start_cnt - s0 == (en_m ? 1 : 0), "R4 start pulses",
                      start_cnt - s0, en_m ? 1 : 0);
            end else begin
                check(ans == 16'hE000 && start_cnt == s0, "R6 unknown refusal", ans, 16'hE000);
                check(conv_chan == ch_m && conv_enable == en_m, "R6 state unchanged",
                      {conv_chan, conv_enable}, {ch_m, en_m});
            end
        end
        check(!quiet_bad, "R9 output quiet in sweep", quiet_bad, 0);
        check(!quiet_bad, "R1 answer framing MSB first", quiet_bad, 0);

        // R7: control refused while a conversion runs
        wait_eoc();
        conv_len = 2000;
        xfer(8'h94, 24);
        check(ans == 16'h2004, "R3 start accepted", ans, 16'h2004);
        s0 = start_cnt;
        xfer(8'h98, 24);
        check(ans == 16'h8000 && start_cnt == s0, "R7 refusal while converting", ans, 16'h8000);
        check(conv_chan == 1'b0 && conv_enable == 1'b1, "R7 state unchanged",
              {conv_chan, conv_enable}, 1);
        xfer(8'h80, 24);
        check(ans == 16'h0000, "R5 fetch masked while converting", ans, 0);
        xfer(8'h88, 24);
        check(ans == 16'h0004, "R2 status while converting", ans, 16'h0004);
        xfer(8'hFF, 24);
        check(ans == 16'hC000, "R6 unknown while converting", ans, 16'hC000);
        wait_eoc();
        xfer(8'h80, 24);
        exp = 32'h2000 + 2 * int'(conv_data);
        check(ans == 16'(exp), "R5 fetch after completion", ans, exp);

        // R10: instruction cut before its 8th edge is discarded
        conv_len = 30;
        s0 = start_cnt;
        xfer(8'h9C, 7);
        check(start_cnt == s0 && conv_chan == 1'b0 && conv_enable == 1'b1,
              "R10 cancelled instruction", {conv_chan, conv_enable}, 1);
        xfer(8'h88, 24);
        check(ans == 16'h2004, "R10 status after cancel", ans, 16'h2004);

        // R11: answer cut after the 8th edge, command still takes effect
        xfer(8'h9C, 10);
        check(start_cnt == s0 + 1 && conv_chan == 1'b1, "R11 truncated control",
              start_cnt - s0, 1);
        wait_eoc();
        check(conv_eoc == 1'b1, "R11 conversion completes", conv_eoc, 1);
        xfer(8'h80, 14);
        check(!quiet_bad, "R9 quiet after truncation", quiet_bad, 0);
        xfer(8'h80, 24);
        exp = 32'h2000 + 2 * int'(conv_data);
        check(ans == 16'(exp), "R11 result after truncation", ans, exp);

        // R7 R3: race between completion and control decode
        for (int len = 205; len <= 245; len++) begin
            wait_eoc();
            conv_len = len;
            xfer(8'h94, 24);
            s0 = start_cnt;
            xfer(8'h94, 24);
            if (ans[15] == 1'b0) begin
                acc_seen++;
                check(ans == 16'h2004 && start_cnt == s0 + 1, "R3 race accepted", ans, 16'h2004);
            end else begin
                ref_seen++;
                check(ans == 16'h8000 && start_cnt == s0, "R7 race refused", ans, 16'h8000);
            end
        end
        check(acc_seen > 0 && ref_seen > 0, "R7 race both outcomes", acc_seen * 256 + ref_seen, 1);

        finish_run();
    end

endmodule